// File: doc/BRIEF.md
# Dual-Mode Synchronous FIFO

A single-clock first-in first-out buffer. Its read side runs in one of two timing modes, and the mode is captured while the master reset is held. In standard mode the block shows no word until it is asked for one. Each read request moves the oldest stored word into the output register. The two status outputs then report empty and full.

In fall-through mode the oldest word is loaded into the output register without any request. A read request then takes that word away and brings up the next one. In this mode the status outputs report output-ready and input-ready. A half-full flag works the same way in both modes.

A synchronous partial reset empties the buffer and keeps the latched mode. This lets a running system flush the buffer without repeating the mode selection.

Top module: `dual_mode_fifo`

## Requirements
- R1: The mode is taken from `fwft_sel_i` on every clock edge while `rst_ni` is low (0 = standard, 1 = fall-through). After release it stays fixed until the next master reset, whatever `fwft_sel_i` or `prst_ni` do.
- R2: In standard mode, a rising edge with `ren_ni` low and at least one stored word loads the oldest word into `rdata_o`. Words come out in write order. With `ren_ni` high, `rdata_o` holds its value.
- R3: In standard mode, a read while empty is ignored. `rdata_o` and the flags stay unchanged.
- R4: A write (`wen_ni` low) while storage holds DEPTH words is ignored. No pointer moves, and the word never appears at the output.
- R5: In standard mode, `ef_or_o` is 1 exactly when storage is empty, and `ff_ir_o` is 1 exactly when storage holds DEPTH words.
- R6: In fall-through mode, a word written into an empty FIFO at edge k is on `rdata_o`, with `ef_or_o` = 1, after edge k+1. No read request is needed. After edge k alone, `ef_or_o` is still 0.
- R7: In fall-through mode, while `ef_or_o` is 1 and `ren_ni` is high, `rdata_o` holds. An edge with `ren_ni` low consumes the shown word and presents the next one. If no next word is stored, `ef_or_o` falls to 0.
- R8: In fall-through mode, `ff_ir_o` is 1 exactly while storage (which excludes the word held in the output register) has room for another word.
- R9: In both modes, `hf_o` is 1 exactly when storage holds more than DEPTH/2 words. A word moved to the output register no longer counts.
- R10: Master reset (`rst_ni` low, asynchronous) empties the FIFO and clears `rdata_o` to 0. The flags then show the empty state: standard mode gives `ef_or_o`=1 and `ff_ir_o`=0; fall-through mode gives `ef_or_o`=0 and `ff_ir_o`=1.
- R11: A partial reset (`prst_ni` low at a rising edge) empties the FIFO and clears `rdata_o` and the output-ready state. It keeps the latched mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Common read/write clock |
| rst_ni | input | 1 | Master reset, asynchronous, active low |
| prst_ni | input | 1 | Partial reset, synchronous, active low |
| fwft_sel_i | input | 1 | Mode select, sampled during master reset |
| wen_ni | input | 1 | Write enable, active low |
| wdata_i | input | W | Write data |
| ren_ni | input | 1 | Read enable, active low |
| rdata_o | output | W | Output data register |
| ef_or_o | output | 1 | Empty flag (standard) / output ready (fall-through) |
| ff_ir_o | output | 1 | Full flag (standard) / input ready (fall-through) |
| hf_o | output | 1 | More than half of storage occupied |

## Verification
The bench first fills the buffer to exactly DEPTH words and then writes one more distinctive word. A design that let this write through would wrap the pointer, and the scoreboard would see that word, or a lost one, during the drain.

The bench also reads from an empty buffer in standard mode. A design that failed here would underflow the count and show stale or garbage data.

In fall-through mode the bench checks the first-word latency edge by edge and holds a shown word for several cycles. It also fills the storage behind an occupied output register, which catches a half-full or input-ready flag that wrongly counts the output word.

Partial resets are issued in both modes, and the mode input is toggled after release. A design that dropped or re-sampled the mode would switch read behaviour.

// File: rtl/dmf_pkg.sv
package dmf_pkg;
  typedef enum logic {
    MODE_STD  = 1'b0,
    MODE_FWFT = 1'b1
  } rd_mode_e;
endpackage

// File: rtl/dmf_storage.sv
module dmf_storage #(
  parameter int W     = 8,
  parameter int DEPTH = 16,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk_i,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [W-1:0]  wdata_i,
  input  logic [AW-1:0] raddr_i,
  output logic [W-1:0]  rdata_o
);
  logic [W-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[waddr_i] <= wdata_i;
  end

  assign rdata_o = mem_q[raddr_i];
endmodule

// File: rtl/dmf_ptrs.sv
module dmf_ptrs #(
  parameter int DEPTH = 16,
  localparam int AW   = $clog2(DEPTH),
  localparam int CW   = AW + 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic          push_i,
  input  logic          pop_i,
  output logic [AW-1:0] wptr_o,
  output logic [AW-1:0] rptr_o,
  output logic [CW-1:0] cnt_o
);
  logic [AW-1:0] wptr_q, rptr_q;
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wptr_q <= '0;
      rptr_q <= '0;
      cnt_q  <= '0;
    end else if (clr_i) begin
      wptr_q <= '0;
      rptr_q <= '0;
      cnt_q  <= '0;
    end else begin
      if (push_i) wptr_q <= wptr_q + AW'(1);
      if (pop_i)  rptr_q <= rptr_q + AW'(1);
      case ({push_i, pop_i})
        2'b10:   cnt_q <= cnt_q + CW'(1);
        2'b01:   cnt_q <= cnt_q - CW'(1);
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  assign wptr_o = wptr_q;
  assign rptr_o = rptr_q;
  assign cnt_o  = cnt_q;
endmodule

// File: rtl/dmf_out_stage.sv
module dmf_out_stage
  import dmf_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  rd_mode_e     mode_i,
  input  logic         ren_ni,
  input  logic         empty_i,
  input  logic [W-1:0] mem_data_i,
  output logic         pop_o,
  output logic [W-1:0] rdata_o,
  output logic         valid_o
);
  logic [W-1:0] data_q;
  logic         valid_q;
  logic         pop;

  always_comb begin
    if (mode_i == MODE_FWFT) pop = !empty_i && (!valid_q || !ren_ni);
    else                     pop = !empty_i && !ren_ni;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_q  <= '0;
      valid_q <= 1'b0;
    end else if (clr_i) begin
      data_q  <= '0;
      valid_q <= 1'b0;
    end else if (pop) begin
      data_q  <= mem_data_i;
      valid_q <= 1'b1;
    end else if (mode_i == MODE_FWFT && !ren_ni) begin
      valid_q <= 1'b0; // last word consumed
    end
  end

  assign pop_o   = pop;
  assign rdata_o = data_q;
  assign valid_o = valid_q;
endmodule

// File: rtl/dual_mode_fifo.sv
module dual_mode_fifo
  import dmf_pkg::*;
#(
  parameter int W     = 8,
  parameter int DEPTH = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         prst_ni,
  input  logic         fwft_sel_i,
  input  logic         wen_ni,
  input  logic [W-1:0] wdata_i,
  input  logic         ren_ni,
  output logic [W-1:0] rdata_o,
  output logic         ef_or_o,
  output logic         ff_ir_o,
  output logic         hf_o
);
  localparam int AW   = $clog2(DEPTH);
  localparam int CW   = AW + 1;
  localparam int HALF = DEPTH / 2;

  rd_mode_e      mode_q;
  logic [AW-1:0] wptr, rptr;
  logic [CW-1:0] cnt;
  logic [W-1:0]  mem_rdata;
  logic          empty, full, push, pop, out_valid, clr;

  // mode is re-captured on every edge while master reset is held
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) mode_q <= rd_mode_e'(fwft_sel_i);
  end

  assign clr   = !prst_ni;
  assign empty = (cnt == '0);
  assign full  = (cnt == CW'(DEPTH));
  assign push  = !wen_ni && !full;

  dmf_storage #(.W(W), .DEPTH(DEPTH)) i_storage (
    .clk_i   (clk_i),
    .we_i    (push && !clr),
    .waddr_i (wptr),
    .wdata_i (wdata_i),
    .raddr_i (rptr),
    .rdata_o (mem_rdata)
  );

  dmf_ptrs #(.DEPTH(DEPTH)) i_ptrs (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (clr),
    .push_i (push),
    .pop_i  (pop),
    .wptr_o (wptr),
    .rptr_o (rptr),
    .cnt_o  (cnt)
  );

  dmf_out_stage #(.W(W)) i_out (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .clr_i      (clr),
    .mode_i     (mode_q),
    .ren_ni     (ren_ni),
    .empty_i    (empty),
    .mem_data_i (mem_rdata),
    .pop_o      (pop),
    .rdata_o    (rdata_o),
    .valid_o    (out_valid)
  );

  always_comb begin
    if (mode_q == MODE_FWFT) begin
      ef_or_o = out_valid;
      ff_ir_o = !full;
    end else begin
      ef_or_o = empty;
      ff_ir_o = full;
    end
  end

  assign hf_o = (cnt > CW'(HALF));
endmodule

// File: rtl/dmf_chk.sv
module dmf_chk #(
  parameter int W     = 8,
  parameter int DEPTH = 16,
  localparam int CW   = $clog2(DEPTH) + 1
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          prst_ni,
  input logic          wen_ni,
  input logic          ren_ni,
  input logic          mode_q,
  input logic [CW-1:0] cnt,
  input logic [W-1:0]  rdata_o,
  input logic          ef_or_o,
  input logic          ff_ir_o
);
  AST_MODE_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(rst_ni) |-> $stable(mode_q)); // R1

  AST_EMPTY_READ_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!mode_q && prst_ni && cnt == '0 && !ren_ni) |=> $stable(rdata_o)); // R3

  AST_NO_OVERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!mode_q && prst_ni && cnt == CW'(DEPTH) && ren_ni) |=> cnt == CW'(DEPTH)); // R4

  AST_CNT_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt <= CW'(DEPTH)); // R4

  AST_STD_FLAGS_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mode_q |-> !(ef_or_o && ff_ir_o)); // R5

  AST_FWFT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_q && prst_ni && ef_or_o && ren_ni) |=> ef_or_o && $stable(rdata_o)); // R7

  AST_PRST_EMPTIES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !prst_ni |=> cnt == '0 && !(mode_q && ef_or_o)); // R11
endmodule

bind dual_mode_fifo dmf_chk #(.W(W), .DEPTH(DEPTH)) i_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .prst_ni (prst_ni),
  .wen_ni  (wen_ni),
  .ren_ni  (ren_ni),
  .mode_q  (mode_q),
  .cnt     (cnt),
  .rdata_o (rdata_o),
  .ef_or_o (ef_or_o),
  .ff_ir_o (ff_ir_o)
);

// File: tb/test_dual_mode_fifo.sv
module test_dual_mode_fifo;
  localparam int W = 8;
  localparam int DEPTH = 16;

  logic clk = 1'b0;
  logic rst_ni = 1'b0, prst_ni = 1'b1, fwft_sel = 1'b0;
  logic wen_ni = 1'b1, ren_ni = 1'b1;
  logic [W-1:0] wdata = '0;
  logic [W-1:0] rdata;
  logic ef_or, ff_ir, hf;

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;
  logic [W-1:0] sb [$];

  always #2 clk = ~clk;

  dual_mode_fifo #(.W(W), .DEPTH(DEPTH)) i_dual_mode_fifo (
    .clk_i(clk), .rst_ni(rst_ni), .prst_ni(prst_ni), .fwft_sel_i(fwft_sel),
    .wen_ni(wen_ni), .wdata_i(wdata), .ren_ni(ren_ni),
    .rdata_o(rdata), .ef_or_o(ef_or), .ff_ir_o(ff_ir), .hf_o(hf)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  // driver: one write cycle, pushes into scoreboard when acceptance is expected
  task automatic drv_write(input logic [W-1:0] d, input bit accept);
    wen_ni = 1'b0; wdata = d;
    step();
    wen_ni = 1'b1;
    if (accept) sb.push_back(d);
  endtask

  // monitor: pops the expected head and compares with the output register
  task automatic mon_cmp(input string req);
    logic [W-1:0] e;
    e = sb.pop_front();
    chk(rdata == e, req, rdata, e);
  endtask

  task automatic std_read(input string req);
    ren_ni = 1'b0;
    step();
    ren_ni = 1'b1;
    mon_cmp(req);
  endtask

  task automatic master_reset(input bit sel);
    @(negedge clk);
    rst_ni = 1'b0; fwft_sel = sel;
    step(); step();
    rst_ni = 1'b1;
    fwft_sel = ~sel; // later changes must not matter
    step();
    sb.delete();
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [W-1:0] hold;
    // ---------------- standard mode ----------------
    master_reset(1'b0);
    chk(rdata == '0, "R10 rdata", rdata, 0);
    chk(ef_or == 1'b1, "R10 ef", ef_or, 1);
    chk(ff_ir == 1'b0, "R10 ff", ff_ir, 0);
    chk(hf == 1'b0, "R9 hf reset", hf, 0);

    ren_ni = 1'b0; step(); ren_ni = 1'b1;
    chk(rdata == '0, "R3 empty read data", rdata, 0);
    chk(ef_or == 1'b1, "R3 empty read flag", ef_or, 1);

    for (int i = 0; i < DEPTH; i++) begin
      drv_write(W'(8'hA0 + i), 1'b1);
      if (i == 0) chk(ef_or == 1'b0, "R5 ef after write", ef_or, 0);
      if (i == DEPTH/2 - 1) chk(hf == 1'b0, "R9 hf at half", hf, 0);
      if (i == DEPTH/2) chk(hf == 1'b1, "R9 hf above half", hf, 1);
      if (i == DEPTH-2) chk(ff_ir == 1'b0, "R5 ff one short", ff_ir, 0);
    end
    chk(ff_ir == 1'b1, "R5 ff at full", ff_ir, 1);
    drv_write(8'hEE, 1'b0);
    chk(ff_ir == 1'b1, "R4 full after dropped write", ff_ir, 1);
    chk(rdata == '0, "R2 no read no change", rdata, 0);

    for (int i = 0; i < DEPTH; i++) begin
      std_read("R2 order");
      if (i == 0) chk(ff_ir == 1'b0, "R5 ff after read", ff_ir, 0);
      if (i == DEPTH/2 - 1) chk(hf == 1'b0, "R9 hf after drain", hf, 0);
    end
    chk(ef_or == 1'b1, "R4 drained, no extra word", ef_or, 1);
    hold = rdata;
    step(); step();
    chk(rdata == hold, "R2 hold", rdata, hold);
    ren_ni = 1'b0; step(); ren_ni = 1'b1;
    chk(rdata == hold, "R3 read empty after drain", rdata, hold);

    drv_write(8'h11, 1'b0); drv_write(8'h22, 1'b0);
    @(negedge clk); prst_ni = 1'b0; step(); prst_ni = 1'b1;
    chk(ef_or == 1'b1, "R11 empty after prst", ef_or, 1);
    chk(rdata == '0, "R11 rdata cleared", rdata, 0);
    drv_write(8'h33, 1'b1);
    step(); step();
    chk(rdata == '0, "R1 still standard after prst", rdata, 0);
    std_read("R11 read after prst");

    // ---------------- fall-through mode ----------------
    master_reset(1'b1);
    chk(ef_or == 1'b0, "R10 or", ef_or, 0);
    chk(ff_ir == 1'b1, "R10 ir", ff_ir, 1);

    drv_write(8'h5A, 1'b1);
    chk(ef_or == 1'b0, "R6 not yet ready", ef_or, 0);
    step();
    chk(ef_or == 1'b1, "R6 ready", ef_or, 1);
    mon_cmp("R6 first word");
    chk(hf == 1'b0, "R9 fwft hf", hf, 0);

    drv_write(8'h61, 1'b1); drv_write(8'h62, 1'b1);
    chk(rdata == 8'h5A, "R7 hold without read", rdata, 8'h5A);
    step();
    chk(rdata == 8'h5A && ef_or, "R7 hold", rdata, 8'h5A);
    ren_ni = 1'b0; step();
    mon_cmp("R7 next word");
    step();
    mon_cmp("R7 last word");
    step(); ren_ni = 1'b1;
    chk(ef_or == 1'b0, "R7 or drops", ef_or, 0);

    for (int i = 0; i < DEPTH + 1; i++) drv_write(W'(8'hC0 + i), 1'b1);
    chk(ff_ir == 1'b0, "R8 ir low at full storage", ff_ir, 0);
    chk(hf == 1'b1, "R9 hf fwft", hf, 1);
    drv_write(8'hEE, 1'b0);
    mon_cmp("R7 head after fill");
    ren_ni = 1'b0; step();
    chk(ff_ir == 1'b1, "R8 ir after consume", ff_ir, 1);
    for (int i = 0; i < DEPTH; i++) begin
      mon_cmp("R4 fwft drain order");
      step();
    end
    ren_ni = 1'b1;
    chk(ef_or == 1'b0, "R4 fwft no extra word", ef_or, 0);

    drv_write(8'h77, 1'b0);
    @(negedge clk); prst_ni = 1'b0; step(); prst_ni = 1'b1;
    chk(ef_or == 1'b0, "R11 or cleared", ef_or, 0);
    drv_write(8'h78, 1'b1);
    step();
    chk(ef_or == 1'b1, "R1 fwft kept after prst", ef_or, 1);
    mon_cmp("R11 fwft word after prst");

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule